// File: doc/BRIEF.md
# Embedded-Clock Word Deserializer with Lock

This block turns a serial bit stream, taken in at one bit per clock cycle, back into 10-bit parallel words. Every 12-bit frame on the line begins with a start bit fixed at 1, carries ten payload bits, and ends with a stop bit fixed at 0. The stop-to-start boundary is therefore always a rising edge, and it serves as the clock embedded in the stream. The block looks for that edge at one candidate bit position at a time. Once it has found the edge at the same position in 80 frames in a row, it declares lock.

While locked, each payload word appears on a 10-bit output together with a recovered word clock whose rising edge coincides with the new word. An active-low lock flag tells downstream logic when the data can be used. When the boundary edge is absent in two frames in a row, lock is dropped and the search starts again without outside help. When the block is not locked, the data and recovered clock outputs are held at all ones. An output-enable input releases all three outputs to high impedance. An active-low powerdown input holds the block in its unlocked starting state.

Top module: `ecw_deser`

## Requirements
- R1: Payload bit 0 is the first bit received after the start bit and lands on dataOut[0]; payload bit 9 lands on dataOut[9]. The complete word appears on dataOut in the cycle after its tenth payload bit is sampled, and it stays there until the next word.
- R2: lockN goes low in the cycle after the 80th consecutive frame boundary (a 0 followed by a 1 at the tested position) is sampled, and not earlier. This holds for the fixed pattern payload 0x01F and for random payload.
- R3: During the search, a tested position that shows no rising edge clears the frame count and moves the tested position one bit later. Under an idle stream of zeros, the first start bit that follows is therefore taken as the boundary at once.
- R4: While locked, one frame without the boundary edge leaves lockN low. A frame that does show the edge clears the miss history, so isolated misses separated by good frames never drop lock.
- R5: The second consecutive missing boundary edge drives lockN high in the cycle after that boundary position is sampled. The search then restarts on its own and locks again after 80 further good frames.
- R6: While lockN is high, dataOut reads 0x3FF and rclkOut reads 1.
- R7: While locked, rclkOut rises in the same cycle that a new word is presented. It stays high for exactly 6 bit cycles and is low in the cycles before the next word.
- R8: When outEn is 0, lockN, dataOut and rclkOut are not driven; they are high impedance.
- R9: While pwrDnN is 0, lockN reads 1 at once, the outputs read all ones, and lock is not acquired. After release, a full 80-frame acquisition is needed again.
- R10: After reset, lockN is 1, dataOut is 0x3FF and rclkOut is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset (power-on reset) |
| pwrDnN | input | 1 | Active-low powerdown, holds the block unlocked |
| outEn | input | 1 | Output enable; 0 puts all outputs in high impedance |
| serIn | input | 1 | Serial line bit |
| lockN | output | 1 | Active-low lock flag |
| dataOut | output | 10 | Recovered payload word, all ones when unlocked |
| rclkOut | output | 1 | Recovered word clock, high when unlocked |

## Verification
The assertions assume that serIn changes only away from the rising clock edge, and that pwrDnN and outEn are steady across an edge. They also assume that the line, once aligned, keeps a stop bit of 0 followed by a start bit of 1 unless a frame is deliberately corrupted. The bench drives every input on the falling edge. It builds frames only through a bench function that fixes the start and stop bits. Corruption comes only as whole frames of zeros, or as a powerdown, so each loss of lock happens at a cycle the bench can predict. Random payloads come from $urandom with a fixed seed and affect only the ten payload bits. An idle run of zeros of random length comes before each acquisition, so the search always starts on the first start bit.

// File: rtl/ecw_deser_pkg.sv
package ecw_deser_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lockState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;   // a payload bit is on serIn this cycle
    logic loadWord;  // the last payload bit is on serIn this cycle
    logic clkFall;   // recovered word clock returns low
    logic locked;    // frame alignment trusted (already gated by powerdown)
  } deserStrobe_t;

endpackage

// File: rtl/ecw_deser_ctrl.sv
module ecw_deser_ctrl
  import ecw_deser_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int LOCK_FRAMES = 80,
  parameter int MISS_LIMIT  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwrDnN,
  input  logic         edgeNow,
  output deserStrobe_t strb
);

  localparam int FRAME_BITS = WORD_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int GOOD_W     = $clog2(LOCK_FRAMES + 1);
  localparam int MISS_W     = $clog2(MISS_LIMIT + 1);
  localparam int FALL_AT    = (FRAME_BITS / 2) - 2;

  lockState_t        state;
  logic [CNT_W-1:0]  bitCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic [MISS_W-1:0] missCnt;
  logic              atBoundary;
  logic              slip;

  assign atBoundary = (bitCnt == '0);
  assign slip       = atBoundary && (state == ST_HUNT) && !edgeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!pwrDnN) begin
      bitCnt <= '0;
    end else if (slip) begin
      bitCnt <= '0;
    end else if (bitCnt == CNT_W'(FRAME_BITS - 1)) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      goodCnt <= '0;
      missCnt <= '0;
    end else if (!pwrDnN) begin
      state   <= ST_HUNT;
      goodCnt <= '0;
      missCnt <= '0;
    end else if (atBoundary) begin
      if (state == ST_HUNT) begin
        if (!edgeNow) begin
          goodCnt <= '0;
        end else if (goodCnt == GOOD_W'(LOCK_FRAMES - 1)) begin
          state   <= ST_LOCKED;
          goodCnt <= '0;
          missCnt <= '0;
        end else begin
          goodCnt <= goodCnt + 1'b1;
        end
      end else begin
        if (edgeNow) begin
          missCnt <= '0;
        end else if (missCnt == MISS_W'(MISS_LIMIT - 1)) begin
          state   <= ST_HUNT;
          missCnt <= '0;
          goodCnt <= '0;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.shiftEn  = (bitCnt >= CNT_W'(1)) && (bitCnt <= CNT_W'(WORD_W));
    strb.loadWord = (bitCnt == CNT_W'(WORD_W));
    strb.clkFall  = (bitCnt == CNT_W'(FALL_AT));
    strb.locked   = (state == ST_LOCKED) && pwrDnN;
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS - 1));

  assert_hunt_slip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && atBoundary && !edgeNow && pwrDnN) |=> (bitCnt == '0 && goodCnt == '0));

  assert_lock_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && $past(state) == ST_HUNT)
      |-> $past(edgeNow && atBoundary && goodCnt == GOOD_W'(LOCK_FRAMES - 1)));

  assert_lock_loss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && $past(state) == ST_LOCKED && $past(pwrDnN))
      |-> $past(atBoundary && !edgeNow && missCnt == MISS_W'(MISS_LIMIT - 1)));

  assert_miss_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && atBoundary && edgeNow && pwrDnN) |=> (missCnt == '0 && state == ST_LOCKED));

endmodule

// File: rtl/ecw_deser_dp.sv
module ecw_deser_dp
  import ecw_deser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              serIn,
  input  deserStrobe_t      strb,
  output logic              edgeNow,
  output logic [WORD_W-1:0] dataVal,
  output logic              rclkVal,
  output logic              lockVal
);

  logic              prevBit;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] wordReg;
  logic              rclkReg;

  assign edgeNow = !prevBit && serIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit <= 1'b1;
    end else if (!pwrDnN) begin
      prevBit <= 1'b1;
    end else begin
      prevBit <= serIn;
    end
  end

  // payload arrives bit 0 first: shift in at the top, toward bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wordReg  <= '1;
      rclkReg  <= 1'b0;
    end else begin
      if (strb.shiftEn) begin
        shiftReg <= {serIn, shiftReg[WORD_W-1:1]};
      end
      if (strb.loadWord) begin
        wordReg <= {serIn, shiftReg[WORD_W-1:1]};
        rclkReg <= 1'b1;
      end else if (strb.clkFall) begin
        rclkReg <= 1'b0;
      end
    end
  end

  always_comb begin
    dataVal = strb.locked ? wordReg : '1;
    rclkVal = strb.locked ? rclkReg : 1'b1;
    lockVal = !strb.locked;
  end

  assert_clk_low_before_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |-> !rclkReg);

  assert_clk_rise_with_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rclkReg) |-> $past(strb.loadWord));

endmodule

// File: rtl/ecw_deser.sv
module ecw_deser
  import ecw_deser_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int LOCK_FRAMES = 80,
  parameter int MISS_LIMIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              outEn,
  input  logic              serIn,
  output logic              lockN,
  output logic [WORD_W-1:0] dataOut,
  output logic              rclkOut
);

  deserStrobe_t      strb;
  logic              edgeNow;
  logic [WORD_W-1:0] dataVal;
  logic              rclkVal;
  logic              lockVal;

  ecw_deser_ctrl #(
    .WORD_W     (WORD_W),
    .LOCK_FRAMES(LOCK_FRAMES),
    .MISS_LIMIT (MISS_LIMIT)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .pwrDnN (pwrDnN),
    .edgeNow(edgeNow),
    .strb   (strb)
  );

  ecw_deser_dp #(
    .WORD_W(WORD_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .pwrDnN (pwrDnN),
    .serIn  (serIn),
    .strb   (strb),
    .edgeNow(edgeNow),
    .dataVal(dataVal),
    .rclkVal(rclkVal),
    .lockVal(lockVal)
  );

  assign lockN   = outEn ? lockVal : 1'bz;
  assign dataOut = outEn ? dataVal : {WORD_W{1'bz}};
  assign rclkOut = outEn ? rclkVal : 1'bz;

endmodule

// File: tb/ecw_deser_tb_top.sv
`timescale 1ns/1ps
module ecw_deser_tb_top;

  localparam int WORD_W     = 10;
  localparam int FRAME_BITS = WORD_W + 2;
  localparam int LOCK_N     = 80;
  localparam logic [9:0] SYNC_WORD = 10'h01F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDnN = 1'b1;
  logic       outEn = 1'b1;
  logic       serIn = 1'b0;
  wire        lockN;
  wire [9:0]  dataOut;
  wire        rclkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ecw_deser dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .pwrDnN (pwrDnN),
    .outEn  (outEn),
    .serIn  (serIn),
    .lockN  (lockN),
    .dataOut(dataOut),
    .rclkOut(rclkOut)
  );

  // bit idx of a frame: 0 start, 1..10 payload (bit 0 first), 11 stop
  function automatic logic frameBit(input logic [9:0] payload, input int idx);
    if (idx == 0) return 1'b1;
    if (idx == FRAME_BITS - 1) return 1'b0;
    return payload[idx-1];
  endfunction

  function automatic logic [31:0] expIdle();
    return 32'h3FF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendBit(input logic b);
    serIn = b;
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [9:0] payload);
    for (int i = 0; i < FRAME_BITS; i++) sendBit(frameBit(payload, i));
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  // idle, then LOCK_N frames; checks lock stays off for LOCK_N-1 frames
  task automatic acquire(input bit randomPayload, input string req);
    logic [9:0] p;
    sendZeros(3 + ($urandom % 20));
    for (int f = 0; f < LOCK_N - 1; f++) begin
      p = randomPayload ? 10'($urandom) : SYNC_WORD;
      sendFrame(p);
    end
    check(lockN === 1'b1, req, 32'(lockN), 32'd1);
    check(dataOut === 10'h3FF && rclkOut === 1'b1, "R6", 32'(dataOut), expIdle());
    p = randomPayload ? 10'($urandom) : SYNC_WORD;
    sendBit(1'b1);
    check(lockN === 1'b0, req, 32'(lockN), 32'd0);
    for (int i = 1; i < FRAME_BITS; i++) sendBit(frameBit(p, i));
    check(dataOut === p, "R1", 32'(dataOut), 32'(p));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] p;
    void'($urandom(32'd5281));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(lockN === 1'b1 && dataOut === 10'h3FF && rclkOut === 1'b1, "R10", 32'(dataOut), 32'h3FF);
    rstN = 1'b1;
    @(negedge clk);
    check(lockN === 1'b1, "R10", 32'(lockN), 32'd1);

    // R2 with sync pattern, R3 immediate alignment after idle zeros
    acquire(1'b0, "R2");

    // R1 random words while locked
    for (int k = 0; k < 20; k++) begin
      p = 10'($urandom);
      sendFrame(p);
      check(dataOut === p && lockN === 1'b0, "R1", 32'(dataOut), 32'(p));
    end

    // R7 word clock timing, bit by bit
    p = 10'h2A5;
    for (int i = 0; i < FRAME_BITS - 2; i++) sendBit(frameBit(p, i));
    check(rclkOut === 1'b0, "R7", 32'(rclkOut), 32'd0);
    sendBit(frameBit(p, FRAME_BITS - 2));
    check(rclkOut === 1'b1 && dataOut === p, "R7", 32'(dataOut), 32'(p));
    sendBit(1'b0);
    p = 10'h0F3;
    for (int i = 0; i < 4; i++) sendBit(frameBit(p, i));
    check(rclkOut === 1'b1, "R7", 32'(rclkOut), 32'd1);
    sendBit(frameBit(p, 4));
    check(rclkOut === 1'b0, "R7", 32'(rclkOut), 32'd0);
    for (int i = 5; i < FRAME_BITS; i++) sendBit(frameBit(p, i));
    check(dataOut === p, "R1", 32'(dataOut), 32'(p));

    // R4 isolated misses keep lock
    for (int k = 0; k < 3; k++) begin
      sendZeros(FRAME_BITS);
      check(lockN === 1'b0, "R4", 32'(lockN), 32'd0);
      p = 10'($urandom);
      sendFrame(p);
      check(lockN === 1'b0 && dataOut === p, "R4", 32'(dataOut), 32'(p));
    end

    // R5 two consecutive misses drop lock
    sendZeros(FRAME_BITS);
    check(lockN === 1'b0, "R5", 32'(lockN), 32'd0);
    sendBit(1'b0);
    check(lockN === 1'b1, "R5", 32'(lockN), 32'd1);
    sendZeros(FRAME_BITS - 1);
    check(dataOut === 10'h3FF && rclkOut === 1'b1, "R6", 32'(dataOut), expIdle());

    // R8 high impedance while unlocked (driven value would be all ones)
    outEn = 1'b0;
    #1;
    check((lockN === 1'bz || lockN === 1'b0) && (rclkOut === 1'bz || rclkOut === 1'b0) &&
          (dataOut === 10'bz || dataOut === 10'h000), "R8", 32'(dataOut), 32'h0);
    @(negedge clk);
    outEn = 1'b1;
    #1;
    check(dataOut === 10'h3FF && lockN === 1'b1, "R8", 32'(dataOut), 32'h3FF);
    @(negedge clk);

    // R5 automatic restart, R2 with random payload
    acquire(1'b1, "R5");

    // R3 a miss mid-search clears the frame count
    sendZeros(FRAME_BITS);
    sendZeros(FRAME_BITS);
    check(lockN === 1'b1, "R5", 32'(lockN), 32'd1);
    for (int f = 0; f < 40; f++) sendFrame(SYNC_WORD);
    sendZeros(FRAME_BITS);
    acquire(1'b0, "R3");

    // R9 powerdown while locked
    sendBit(1'b1);
    pwrDnN = 1'b0;
    #1;
    check(lockN === 1'b1 && dataOut === 10'h3FF && rclkOut === 1'b1, "R9", 32'(lockN), 32'd1);
    @(negedge clk);
    for (int f = 0; f < LOCK_N + 2; f++) sendFrame(SYNC_WORD);
    check(lockN === 1'b1, "R9", 32'(lockN), 32'd1);
    pwrDnN = 1'b1;
    acquire(1'b0, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule